// File: doc/BRIEF.md
# Multi-Port Register Bank with Priority Writes

A small bank of byte-wide registers held in flip-flops, shared by several independent clients inside one clock domain. Every reader owns an address input and a full-width multiplexer, so any number of readers can look at any registers in the same cycle without waiting for a turn. Every writer owns an address decoder and an enable, so several writers can store values on the same clock edge.

When two or more enabled writers name the same register in one cycle, the writer with the lowest port index wins and only its byte is stored. Each overridden writer sees a one-cycle pulse on its own `wr_lost` bit, so the client can retry or treat the loss as acceptable. Reads are purely combinational and show the bank as it stood before the coming edge. A write therefore becomes visible on the read ports in the cycle after the edge that stores it.

Top module: `mprf_bank`

## Requirements
- R1: While `rst_n` is low, every register reads back as 0x00 and `wr_lost` is all zeros. Both hold until the first write after reset is released.
- R2: Each read port returns `rd_data[p*8 +: 8]` = contents of the register selected by `rd_addr[p*AW +: AW]`, combinationally and independently of every other read port.
- R3: A read of a register in the same cycle as a write to it returns the old contents. The new contents appear once the clock edge has passed.
- R4: Enabled writers that address different registers all store their bytes on the same edge.
- R5: When several enabled writers address one register, the byte stored is that of the lowest-indexed writer among them. Writer 0 has the highest priority.
- R6: `wr_lost[i]` is high during exactly the one cycle after an edge at which writer i was enabled and a lower-indexed enabled writer named the same address. Otherwise it is low, and `wr_lost[0]` is never high.
- R7: A writer with `wr_en[i]` low changes no register, whatever its address and data. It never causes another writer's loss.
- R8: `DEPTH` must be a power of two from 2 to 256, and `NRD` and `NWR` must each be at least 1. Any other value stops elaboration. Address width is log2(`DEPTH`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | NWR | Per-writer write enable |
| wr_addr | input | NWR*AW | Writer i address in bits [i*AW +: AW] |
| wr_data | input | NWR*REG_W | Writer i byte in bits [i*REG_W +: REG_W] |
| wr_lost | output | NWR | Writer i was overridden at the previous edge |
| rd_addr | input | NRD*AW | Read port p address in bits [p*AW +: AW] |
| rd_data | output | NRD*REG_W | Read port p data in bits [p*REG_W +: REG_W] |

## Verification
Read data has no latency: the bench drives read addresses at the falling edge and samples `rd_data` a nanosecond later. It compares the sample against a model that has not yet taken that cycle's writes, which covers the old-value rule. A stored byte shows up only on reads issued in a later cycle, so the bench reads a written address again at the next falling edge. The loss flag is registered and is due one rising edge after the colliding request. For that reason the driver queues the expected `wr_lost` vector when it drives a request, and a monitor pops and compares it one nanosecond after the next rising edge.

// File: rtl/mprf_pkg.sv
package mprf_pkg;
   // Width of one storage cell.
   localparam int unsigned CELL_W = 8;
   // Largest bank size that a byte-wide address space allows.
   localparam int unsigned MAX_DEPTH = 256;

   // True when v is a power of two.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/mprf_wr_decode.sv
// Per-writer address decoder: each writer drives one hit line per register.
// Output layout groups the hits of all writers for one register together:
// hit[r*NWR + i] is writer i targeting register r.
module mprf_wr_decode #(
   parameter int unsigned NWR   = 2,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 4
) (
   input  logic [NWR-1:0]       wr_en,
   input  logic [NWR*AW-1:0]    wr_addr,
   output logic [DEPTH*NWR-1:0] hit
);
   for (genvar gi = 0; gi < NWR; gi++) begin : g_wr
      logic [AW-1:0] addr_i;
      assign addr_i = wr_addr[gi*AW +: AW];
      for (genvar gr = 0; gr < DEPTH; gr++) begin : g_reg
         assign hit[gr*NWR + gi] = wr_en[gi] && (addr_i == AW'(gr));
      end
   end
endmodule

// File: rtl/mprf_prio_pick.sv
// Fixed-priority picker for one register: the lowest set request index wins.
module mprf_prio_pick #(
   parameter int unsigned NWR = 2
) (
   input  logic [NWR-1:0] req,
   output logic [NWR-1:0] grant,
   output logic [NWR-1:0] lose
);
   if (NWR == 1) begin : g_single
      assign grant = req;
      assign lose  = '0;
   end else begin : g_multi
      always_comb begin
         logic taken;
         taken = 1'b0;
         grant = '0;
         for (int i = 0; i < NWR; i++) begin
            grant[i] = req[i] && !taken;
            taken    = taken || req[i];
         end
         lose = req & ~grant;
      end
   end
endmodule

// File: rtl/mprf_rd_mux.sv
// Full read multiplexer for one read port.
module mprf_rd_mux #(
   parameter int unsigned REG_W = 8,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned AW    = 4
) (
   input  logic [REG_W-1:0] cells [DEPTH],
   input  logic [AW-1:0]    addr,
   output logic [REG_W-1:0] data
);
   assign data = cells[addr];
endmodule

// File: rtl/mprf_bank.sv
module mprf_bank #(
   parameter int unsigned REG_W = mprf_pkg::CELL_W,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned NRD   = 2,
   parameter int unsigned NWR   = 2,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NWR-1:0]       wr_en,
   input  logic [NWR*AW-1:0]    wr_addr,
   input  logic [NWR*REG_W-1:0] wr_data,
   output logic [NWR-1:0]       wr_lost,
   input  logic [NRD*AW-1:0]    rd_addr,
   output logic [NRD*REG_W-1:0] rd_data
);
   // R8: parameter legality, checked while elaborating
   if (DEPTH < 2 || DEPTH > mprf_pkg::MAX_DEPTH || !mprf_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("mprf_bank: DEPTH must be a power of two in 2..256");
   end
   if (NRD < 1 || NWR < 1) begin : g_bad_ports
      $error("mprf_bank: NRD and NWR must be at least 1");
   end

   logic [REG_W-1:0]     cells [DEPTH];
   logic [DEPTH*NWR-1:0] hit;
   logic [DEPTH*NWR-1:0] lose_all;
   logic [NWR-1:0]       lost_nxt;

   mprf_wr_decode #(.NWR(NWR), .DEPTH(DEPTH), .AW(AW)) dec_i (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .hit    (hit)
   );

   for (genvar gr = 0; gr < DEPTH; gr++) begin : g_cell
      logic [NWR-1:0]   req;
      logic [NWR-1:0]   grant;
      logic [NWR-1:0]   lose;
      logic [REG_W-1:0] nxt;

      assign req = hit[gr*NWR +: NWR];

      mprf_prio_pick #(.NWR(NWR)) pick_i (
         .req  (req),
         .grant(grant),
         .lose (lose)
      );

      assign lose_all[gr*NWR +: NWR] = lose;

      // grant is one-hot or zero, so an OR of gated bytes selects the winner
      always_comb begin
         nxt = '0;
         for (int i = 0; i < NWR; i++) begin
            if (grant[i]) nxt = nxt | wr_data[i*REG_W +: REG_W];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cells[gr] <= '0;
         else if (|req) cells[gr] <= nxt;
      end
   end

   // A writer targets one register at a time, so OR across registers
   always_comb begin
      lost_nxt = '0;
      for (int r = 0; r < DEPTH; r++) begin
         lost_nxt = lost_nxt | lose_all[r*NWR +: NWR];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_lost <= '0;
      else        wr_lost <= lost_nxt;
   end

   for (genvar gp = 0; gp < NRD; gp++) begin : g_rd
      mprf_rd_mux #(.REG_W(REG_W), .DEPTH(DEPTH), .AW(AW)) mux_i (
         .cells(cells),
         .addr (rd_addr[gp*AW +: AW]),
         .data (rd_data[gp*REG_W +: REG_W])
      );
   end
endmodule

// File: rtl/mprf_bank_chk.sv
module mprf_bank_chk #(
   parameter int unsigned REG_W = 8,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned NRD   = 2,
   parameter int unsigned NWR   = 2,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NWR-1:0]       wr_en,
   input logic [NWR*AW-1:0]    wr_addr,
   input logic [REG_W-1:0]     wr_data0,
   input logic [NWR-1:0]       wr_lost,
   input logic [NRD*AW-1:0]    rd_addr,
   input logic [NRD*REG_W-1:0] rd_data
);
   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         rst_lost_clear_chk: assert (wr_lost == '0);
      end
   end

   // R6
   top_writer_never_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lost[0]);

   // R5
   writer0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en[0]) && rd_addr[AW-1:0] == $past(wr_addr[AW-1:0]))
      |-> rd_data[REG_W-1:0] == $past(wr_data0));

   // R3
   read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) == '0 && $stable(rd_addr)) |-> $stable(rd_data));

   for (genvar gi = 1; gi < NWR; gi++) begin : g_lose
      logic beaten;
      always_comb begin
         beaten = 1'b0;
         for (int j = 0; j < gi; j++) begin
            if (wr_en[j] && wr_addr[j*AW +: AW] == wr_addr[gi*AW +: AW]) beaten = 1'b1;
         end
         beaten = beaten && wr_en[gi];
      end
      // R6
      lost_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         beaten |=> wr_lost[gi]);
      // R6 R7
      lost_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !beaten |=> !wr_lost[gi]);
   end
endmodule

bind mprf_bank mprf_bank_chk #(
   .REG_W(REG_W), .DEPTH(DEPTH), .NRD(NRD), .NWR(NWR)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data0(wr_data[REG_W-1:0]),
   .wr_lost (wr_lost),
   .rd_addr (rd_addr),
   .rd_data (rd_data)
);

// File: tb/mprf_bank_tb_top.sv
`timescale 1ns/1ps
module mprf_bank_tb_top;
   localparam int W = 8, DEPTH = 16, NRD = 2, NWR = 2, AW = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic                 rst_n;
   logic [NWR-1:0]       wr_en;
   logic [NWR*AW-1:0]    wr_addr;
   logic [NWR*W-1:0]     wr_data;
   logic [NWR-1:0]       wr_lost;
   logic [NRD*AW-1:0]    rd_addr;
   logic [NRD*W-1:0]     rd_data;

   mprf_bank #(.REG_W(W), .DEPTH(DEPTH), .NRD(NRD), .NWR(NWR)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_lost(wr_lost), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   logic [W-1:0]   model [DEPTH];
   logic [NWR-1:0] lost_q [$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Driver: one call per clock cycle; reads are checked against pre-write state
   task automatic cycle(bit e0, int a0, int d0, bit e1, int a1, int d1,
                        int r0, int r1, string tag);
      @(negedge clk);
      wr_en   = {e1, e0};
      wr_addr = {AW'(a1), AW'(a0)};
      wr_data = {W'(d1), W'(d0)};
      rd_addr = {AW'(r1), AW'(r0)};
      #1;
      check(tag, rd_data[0 +: W], model[r0]);
      check(tag, rd_data[W +: W], model[r1]);
      lost_q.push_back({(e0 && e1 && a0 == a1), 1'b0});
      if (e1) model[a1] = W'(d1);
      if (e0) model[a0] = W'(d0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = '0;
      for (int r = 0; r < DEPTH; r++) model[r] = '0;
      repeat (2) @(negedge clk);
      checks++;
      if (wr_lost !== '0) begin
         errors++;
         $display("FAIL R1: actual lost %b expected 00", wr_lost);
      end
      rst_n = 1'b1;
   endtask

   // Monitor: registered loss flags are due one rising edge after the request
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (lost_q.size() > 0) begin
            logic [NWR-1:0] exp;
            exp = lost_q.pop_front();
            checks++;
            if (wr_lost !== exp) begin
               errors++;
               $display("FAIL R6: actual lost %b expected %b", wr_lost, exp);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n   = 1'b0;
      wr_en   = '0;
      wr_addr = '0;
      wr_data = '0;
      rd_addr = '0;
      for (int r = 0; r < DEPTH; r++) model[r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: bank empty after reset, both ends of the address range
      cycle(0, 0, 0, 0, 0, 0, 0, 15, "R1");
      // R4 R3: distinct writes, same-cycle reads see old data
      cycle(1, 3, 'hA5, 1, 7, 'h3C, 3, 7, "R3");
      // R2 R4: both ports read both new values
      cycle(0, 0, 0, 0, 0, 0, 3, 7, "R4");
      cycle(0, 0, 0, 0, 0, 0, 7, 3, "R2");
      // R5: collision on register 5, writer 0 wins, writer 1 flagged
      cycle(1, 5, 'h11, 1, 5, 'h22, 5, 5, "R3");
      cycle(0, 0, 0, 0, 0, 0, 5, 3, "R5");
      // R7: disabled writer 0 on same address does not beat writer 1
      cycle(0, 9, 'hFF, 1, 9, 'h77, 9, 0, "R7");
      cycle(0, 0, 0, 0, 0, 0, 9, 9, "R7");
      // R7: disabled writer 1 leaves register 3 untouched
      cycle(0, 0, 0, 0, 3, 'hEE, 3, 0, "R7");
      cycle(0, 0, 0, 0, 0, 0, 3, 0, "R7");
      // R5 R6: back-to-back collisions at both address extremes
      cycle(1, 15, 'h5A, 1, 15, 'hC3, 15, 0, "R6");
      cycle(1, 0, 'h81, 1, 0, 'h18, 15, 0, "R5");
      cycle(0, 0, 0, 0, 0, 0, 0, 15, "R5");
      // R4 R2: fill the whole bank, two registers per cycle
      for (int k = 0; k < DEPTH / 2; k++) begin
         cycle(1, 2*k, 16*k + 1, 1, 2*k + 1, 255 - k, 2*k, 2*k + 1, "R4");
      end
      for (int k = 0; k < DEPTH / 2; k++) begin
         cycle(0, 0, 0, 0, 0, 0, 2*k + 1, 2*k, "R2");
      end
      // R1: mid-run reset clears contents
      cycle(0, 0, 0, 0, 0, 0, 0, 0, "R2");
      @(posedge clk);
      #2;
      do_reset();
      cycle(0, 0, 0, 0, 0, 0, 1, 14, "R1");
      cycle(0, 0, 0, 0, 0, 0, 6, 9, "R1");
      @(negedge clk);
      wr_en = '0;
      @(posedge clk);
      #2;
      checks++;
      if (lost_q.size() != 0) begin
         errors++;
         $display("FAIL R6: actual %0d pending expected 0", lost_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule